// File: doc/BRIEF.md
# Multibit Path Metric Update Unit

This block sits at the tail of one component decoder in a list decoder for polar codes. Each decision step resolves four bits together instead of one. The block receives the four soft values from the last retained decoding stage and the running metric of the path that produced them. From these it computes the metric of every one of the sixteen ways that path could be extended by four bits. The decoder's sorter then ranks these metrics against the candidates of the other list members, which is outside this block.

Each candidate's four bits are first passed through the four-bit polar encoding. Each encoded bit that disagrees with the hard decision of its soft value costs that value's magnitude. This is the usual hard approximation of ln(1+e^x), applied in the log-likelihood domain. Candidates that would place a 1 on a frozen position are forced to a reserved minus-infinity code, so they never survive selection. All sixteen results are registered and leave the block one cycle after the input strobe.

Top module: `mbit_metric_update`

## Requirements
- R1: Each soft input is 6 bits in sign-magnitude form: bit 5 is the sign (1 = negative) and bits 4:0 are the magnitude. +0 and -0 are both zero. Soft value j (j = 1..4) occupies `llr_i[6j-1:6j-6]`.
- R2: Candidate c (0..15) carries bits a1..a4 with a1 = c[3], a2 = c[2], a3 = c[1] and a4 = c[0]. Its metric appears on `cand_metric_o[8c+7:8c]`. Its encoded bits are e1 = a1^a2^a3^a4, e2 = a2^a4, e3 = a3^a4 and e4 = a4.
- R3: An unforced candidate's metric is `prev_metric_i` (8-bit two's complement) minus the sum of the magnitudes of every soft value j whose sign bit differs from e_j. The result is never above the previous metric.
- R4: An unforced result below -127 saturates to -127, so a live path never shows the minus-infinity code -128 (8'h80).
- R5: `frozen_i` bit b marks the position held by candidate bit b (bit 3 = a1, bit 0 = a4). Any candidate c with (c & frozen_i) != 0 outputs 8'h80. With a zero mask, no candidate is forced.
- R6: A previous metric of 8'h80 makes all sixteen outputs 8'h80.
- R7: `out_valid_o` is high exactly in the cycle after a cycle with `in_valid_i` high. The metrics computed from that cycle's inputs are on the outputs during that cycle.
- R8: While `in_valid_i` is low, the metric outputs keep their last values whatever the other inputs do.
- R9: After reset, `out_valid_o` is 0 and every candidate metric is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Input strobe; loads a new set of results |
| llr_i | input | 24 | Four sign-magnitude soft values |
| prev_metric_i | input | 8 | Metric of the path being extended |
| frozen_i | input | 4 | Frozen-position mask for the four bits |
| out_valid_o | output | 1 | Results valid strobe |
| cand_metric_o | output | 128 | Sixteen 8-bit candidate metrics |

## Verification
On every cycle the assertions check the one-cycle strobe relation and that results are held between strobes. They check that each masked candidate carries the minus-infinity code, that a minus-infinity parent poisons every child, and that every live candidate lies between -127 and its parent's metric. The exact value of each candidate follows from the encoding pattern and the sign disagreements. The bench's scenarios alone can show this: a table of soft-value and mask patterns is compared against a model written from the disagreement rule. Directed cases cover saturation, negative zero and reset.

// File: rtl/mbm_pkg.sv
package mbm_pkg;

  // Encoded bit pattern of a candidate under the natural-order Kronecker
  // power of [[1,0],[1,1]]. Row r has a 1 in column c when c's bits are a
  // subset of r's bits. Candidate bit (nbits-1-i) is input bit i.
  function automatic logic [63:0] enc_pattern(input int cand, input int nbits);
    logic [63:0] r;
    r = '0;
    for (int j = 0; j < nbits; j++) begin
      for (int i = 0; i < nbits; i++) begin
        if (((i & j) == j) && (((cand >> (nbits - 1 - i)) & 1) != 0)) begin
          r[j] = ~r[j];
        end
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/mbm_llr_conv.sv
// Sign-magnitude soft value to sign-extended two's complement.
module mbm_llr_conv #(
  parameter int LLR_W = 6,
  parameter int OUT_W = 12
) (
  input  logic [LLR_W-1:0] sm_i,
  output logic [OUT_W-1:0] tc_o
);

  logic [OUT_W-1:0] mag;

  always_comb begin
    mag  = {{(OUT_W-LLR_W+1){1'b0}}, sm_i[LLR_W-2:0]};
    tc_o = sm_i[LLR_W-1] ? (~mag + 1'b1) : mag;
  end

endmodule

// File: rtl/mbm_cand_unit.sv
// Metric of one fixed candidate pattern: accumulate, saturate, force.
module mbm_cand_unit #(
  parameter int NBITS = 4,
  parameter int PM_W  = 8,
  parameter int SUM_W = 12,
  parameter int CAND  = 0
) (
  input  logic [NBITS*SUM_W-1:0] llr_tc_i,
  input  logic [PM_W-1:0]        prev_i,
  input  logic [NBITS-1:0]       frozen_i,
  output logic [PM_W-1:0]        metric_o
);

  localparam logic [NBITS-1:0] ENC      = NBITS'(mbm_pkg::enc_pattern(CAND, NBITS));
  localparam logic [NBITS-1:0] CAND_BITS = NBITS'(CAND);
  localparam logic [PM_W-1:0]  NEG_INF  = {1'b1, {(PM_W-1){1'b0}}};
  localparam logic signed [SUM_W-1:0] SAT_LO =
    {{(SUM_W-PM_W+1){1'b1}}, {(PM_W-2){1'b0}}, 1'b1};

  logic signed [SUM_W-1:0] acc;
  logic        [SUM_W-1:0] v;
  logic                    forced;

  always_comb begin
    acc = {{(SUM_W-PM_W){prev_i[PM_W-1]}}, prev_i};
    for (int j = 0; j < NBITS; j++) begin
      v = llr_tc_i[j*SUM_W +: SUM_W];
      if (ENC[j]) begin
        // encoded 1: pay the positive part of the soft value
        acc = acc - (v[SUM_W-1] ? '0 : v);
      end else begin
        // encoded 0: pay the negative part of the soft value
        acc = acc + (v[SUM_W-1] ? v : '0);
      end
    end

    forced = (prev_i == NEG_INF) || ((CAND_BITS & frozen_i) != '0);

    if (forced) begin
      metric_o = NEG_INF;
    end else if (acc < SAT_LO) begin
      metric_o = SAT_LO[PM_W-1:0];
    end else begin
      metric_o = acc[PM_W-1:0];
    end
  end

endmodule

// File: rtl/mbit_metric_update.sv
module mbit_metric_update #(
  parameter int K     = 2,
  parameter int LLR_W = 6,
  parameter int PM_W  = 8,
  localparam int NBITS = 1 << K,
  localparam int NCAND = 1 << NBITS,
  localparam int SUM_W = PM_W + K + 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  in_valid_i,
  input  logic [NBITS*LLR_W-1:0] llr_i,
  input  logic [PM_W-1:0]       prev_metric_i,
  input  logic [NBITS-1:0]      frozen_i,
  output logic                  out_valid_o,
  output logic [NCAND*PM_W-1:0] cand_metric_o
);

  logic [NBITS*SUM_W-1:0] llr_tc;
  logic [NCAND*PM_W-1:0]  cand_comb;
  logic [NCAND*PM_W-1:0]  metric_d, metric_q;
  logic                   valid_d, valid_q;

  for (genvar j = 0; j < NBITS; j++) begin : g_conv
    mbm_llr_conv #(
      .LLR_W(LLR_W),
      .OUT_W(SUM_W)
    ) u_conv (
      .sm_i(llr_i[j*LLR_W +: LLR_W]),
      .tc_o(llr_tc[j*SUM_W +: SUM_W])
    );
  end

  for (genvar c = 0; c < NCAND; c++) begin : g_cand
    mbm_cand_unit #(
      .NBITS(NBITS),
      .PM_W (PM_W),
      .SUM_W(SUM_W),
      .CAND (c)
    ) u_cand (
      .llr_tc_i(llr_tc),
      .prev_i  (prev_metric_i),
      .frozen_i(frozen_i),
      .metric_o(cand_comb[c*PM_W +: PM_W])
    );
  end

  // next state
  always_comb begin
    valid_d  = in_valid_i;
    metric_d = in_valid_i ? cand_comb : metric_q;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      metric_q <= '0;
    end else begin
      valid_q  <= valid_d;
      metric_q <= metric_d;
    end
  end

  assign out_valid_o   = valid_q;
  assign cand_metric_o = metric_q;

endmodule

// File: rtl/mbm_update_chk.sv
module mbm_update_chk #(
  parameter int K    = 2,
  parameter int PM_W = 8,
  localparam int NBITS = 1 << K,
  localparam int NCAND = 1 << NBITS
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  in_valid_i,
  input logic [PM_W-1:0]       prev_metric_i,
  input logic [NBITS-1:0]      frozen_i,
  input logic                  out_valid_o,
  input logic [NCAND*PM_W-1:0] cand_metric_o
);

  localparam logic [PM_W-1:0] NEG_INF = {1'b1, {(PM_W-1){1'b0}}};

  a_r7_strobe_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);

  a_r7_no_spurious_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);

  a_r8_hold_between_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(cand_metric_o));

  for (genvar c = 0; c < NCAND; c++) begin : g_chk
    localparam logic [NBITS-1:0] CB = NBITS'(c);

    // R5: masked candidates carry minus infinity
    a_r5_frozen_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i |=> (((CB & $past(frozen_i)) == '0) ||
                      (cand_metric_o[c*PM_W +: PM_W] == NEG_INF)));

    // R6: a dead parent gives dead children
    a_r6_dead_parent: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i && prev_metric_i == NEG_INF) |=>
        (cand_metric_o[c*PM_W +: PM_W] == NEG_INF));

    // R3, R4: a live candidate never rises above its parent nor hits -128
    a_r4_live_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i && prev_metric_i != NEG_INF && ((CB & frozen_i) == '0)) |=>
        ((cand_metric_o[c*PM_W +: PM_W] != NEG_INF) &&
         ($signed(cand_metric_o[c*PM_W +: PM_W]) <= $signed($past(prev_metric_i)))));
  end

endmodule

bind mbit_metric_update mbm_update_chk #(
  .K   (K),
  .PM_W(PM_W)
) u_mbm_update_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_valid_i   (in_valid_i),
  .prev_metric_i(prev_metric_i),
  .frozen_i     (frozen_i),
  .out_valid_o  (out_valid_o),
  .cand_metric_o(cand_metric_o)
);

// File: tb/mbit_metric_update_bench.sv
`timescale 1ns/1ps
module mbit_metric_update_bench;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [23:0]  llr;
  logic [7:0]   prev;
  logic [3:0]   mask;
  logic         out_valid;
  logic [127:0] metrics;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  mbit_metric_update u_mbit_metric_update (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .in_valid_i   (in_valid),
    .llr_i        (llr),
    .prev_metric_i(prev),
    .frozen_i     (mask),
    .out_valid_o  (out_valid),
    .cand_metric_o(metrics)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Stimulus table: {mask, prev, s4, s3, s2, s1}; 6'd32+m means -m.
  localparam int NVEC = 8;
  localparam logic [35:0] VEC [NVEC] = '{
    {4'b0000, 8'd0,   6'd10, 6'd10, 6'd10, 6'd10},
    {4'b0000, 8'd20,  6'd37, 6'd3,  6'd44, 6'd1 },
    {4'b1000, 8'd100, 6'd31, 6'd63, 6'd0,  6'd32},
    {4'b1010, 8'd200, 6'd7,  6'd7,  6'd39, 6'd39},
    {4'b0001, 8'd250, 6'd50, 6'd12, 6'd2,  6'd60},
    {4'b0000, 8'd156, 6'd31, 6'd31, 6'd31, 6'd31},
    {4'b1111, 8'd5,   6'd1,  6'd33, 6'd1,  6'd33},
    {4'b0110, 8'd127, 6'd63, 6'd63, 6'd63, 6'd63}
  };

  // Model written from R1..R6: disagreement between each encoded bit and
  // the sign of its soft value costs that value's magnitude.
  function automatic logic [7:0] model(input logic [23:0] s, input logic [7:0] p,
                                       input logic [3:0] m, input int c);
    logic a1, a2, a3, a4;
    logic [3:0] e;
    int acc;
    if (p == 8'h80) return 8'h80;
    if ((c[3:0] & m) != 4'b0) return 8'h80;
    a1 = c[3]; a2 = c[2]; a3 = c[1]; a4 = c[0];
    e[0] = a1 ^ a2 ^ a3 ^ a4;
    e[1] = a2 ^ a4;
    e[2] = a3 ^ a4;
    e[3] = a4;
    acc = int'($signed(p));
    for (int j = 0; j < 4; j++) begin
      if (s[6*j+5] != e[j]) acc = acc - int'(s[6*j +: 5]);
    end
    if (acc < -127) acc = -127;
    return acc[7:0];
  endfunction

  task automatic check8(input string req, input int c, input logic [7:0] act,
                        input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cand %0d: actual %h expected %h", req, c, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic apply(input logic [23:0] s, input logic [7:0] p, input logic [3:0] m);
    @(negedge clk);
    llr = s; prev = p; mask = m; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic compare_all(input string req, input logic [23:0] s,
                             input logic [7:0] p, input logic [3:0] m);
    for (int c = 0; c < 16; c++) check8(req, c, metrics[8*c +: 8], model(s, p, m, c));
  endtask

  initial begin
    logic [127:0] snap;
    rst_n = 1'b0; in_valid = 1'b0; llr = '0; prev = '0; mask = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check1("R9 valid", out_valid, 1'b0);
    check8("R9 metrics", 0, metrics[7:0], 8'h00);
    check8("R9 metrics", 15, metrics[127:120], 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R1, R2, R3, R4, R5, R7
    for (int v = 0; v < NVEC; v++) begin
      apply(VEC[v][23:0], VEC[v][31:24], VEC[v][35:32]);
      check1("R7 strobe", out_valid, 1'b1);
      compare_all("R3/R5 table", VEC[v][23:0], VEC[v][31:24], VEC[v][35:32]);
    end

    // R2/R3 hand values: all soft values +10, parent 0
    apply({4{6'd10}}, 8'd0, 4'b0000);
    check8("R3 all agree", 0, metrics[7:0], 8'd0);
    check8("R2 a1 only", 8, metrics[71:64], 8'hF6);
    check8("R2 a4 only", 1, metrics[15:8], 8'hD8);

    // R4: saturation at -127
    apply({4{6'd31}}, 8'd156, 4'b0000);
    check8("R4 saturate", 1, metrics[15:8], 8'h81);
    check8("R4 unsat", 0, metrics[7:0], 8'd156);

    // R1: negative zero behaves as zero
    apply({6'd32, 6'd32, 6'd32, 6'd32}, 8'd40, 4'b0000);
    check8("R1 neg zero", 15, metrics[127:120], 8'd40);

    // R5: full mask leaves only candidate 0 live
    apply({4{6'd5}}, 8'd9, 4'b1111);
    check8("R5 live", 0, metrics[7:0], 8'd9);
    check8("R5 forced", 7, metrics[63:56], 8'h80);

    // R6: dead parent
    apply({4{6'd5}}, 8'h80, 4'b0000);
    compare_all("R6 dead parent", {4{6'd5}}, 8'h80, 4'b0000);

    // R7, R8: no strobe -> outputs held, strobe low
    snap = metrics;
    @(negedge clk);
    llr = {4{6'd63}}; prev = 8'd3; mask = 4'b0101;
    repeat (2) @(negedge clk);
    check1("R7 no strobe", out_valid, 1'b0);
    checks++;
    if (metrics !== snap) begin
      fails++;
      $display("FAIL R8 hold: actual %h expected %h", metrics, snap);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule